// File: doc/BRIEF.md
# Eight-Bit Addressable Output Latch with Conditional Clear

This block keeps a bank of output bits, eight by default, and writes them one at a time. A single serial data input and a binary bit-select choose which bit is written. An active-low write enable gates the write. An active-low clear changes what happens to the bits that are not selected.

The two controls give four modes. In **load**, the selected bit takes the data and the other bits stay as they are. In **keep**, every bit stays as it is. In **demux**, the selected bit takes the data and every other bit is forced to zero, so the block works as a 1-of-N demultiplexer. In **wipe**, the whole bank is forced to zero. The clear is therefore conditional: with the enable active it does not reset the whole bank.

The bank is built from flip-flops on a system clock. Both controls are sampled as levels on each rising edge. Each output is registered, so a change shows up at the outputs one clock after it is sampled. A synchronous active-high reset, separate from the functional clear, puts the bank at zero.

Top module: `addr_latch_bank`

## Requirements
- R1: One cycle after a rising clock edge that samples `rst` high, every bit of `q` is 0.
- R2: With `clr_n`=1 and `wr_en_n`=0 (load), the next edge sets bit `q[sel]` to `din` and leaves every other bit unchanged.
- R3: `sel` is read as an unsigned binary number with `sel[ADDR_W-1]` as the most significant bit. The value k selects `q[k]`, so 0 selects `q[0]` and 7 selects `q[7]` at the default width.
- R4: With `clr_n`=1 and `wr_en_n`=1 (keep), `q` does not change, whatever `din` and `sel` do.
- R5: With `clr_n`=0 and `wr_en_n`=1 (wipe), the next edge forces every bit of `q` to 0.
- R6: With `clr_n`=0 and `wr_en_n`=0 (demux), the next edge sets `q[sel]` to `din` and forces every other bit to 0.
- R7: While `wr_en_n` stays low, the selected bit follows `din` on every cycle. After `wr_en_n` returns high, the bit keeps the `din` value sampled in the last enabled cycle.
- R8: `sel` may change only in a cycle where `wr_en_n` is high or was high in the previous cycle. A bit that was written earlier is not disturbed by a later load to a different address.
- R9: `rst` takes priority over every mode: a write or demux requested in the same cycle as `rst` still leaves `q` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset to all zeros |
| din | input | 1 | Serial data bit for the selected output |
| sel | input | ADDR_W | Binary select of the output bit to write |
| wr_en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low conditional clear |
| q | output | 2**ADDR_W | Registered output bank |

## Verification
In demux mode, two actions land on the same clock edge: the selected bit is written and the other bits are cleared. A bank that is already zero would hide a missing clear. The bench therefore first loads all ones into the bank through load-mode writes. It then applies demux with each select value and each data value, and compares the whole bank to a one-hot or all-zero pattern that it computes. The reset-versus-write overlap is provoked by raising `rst` while load is requested, and is judged by an all-zero bank one cycle later.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

   typedef enum logic [1:0] {
      MODE_LOAD  = 2'd0,
      MODE_KEEP  = 2'd1,
      MODE_DEMUX = 2'd2,
      MODE_WIPE  = 2'd3
   } op_mode_t;

   localparam int unsigned MAX_ADDR_W = 6;

endpackage

// File: rtl/addr_latch_mode.sv
module addr_latch_mode
   import addr_latch_pkg::*;
(
   input  logic     clr_n,
   input  logic     wr_en_n,
   output op_mode_t mode
);

   always_comb begin
      unique case ({clr_n, wr_en_n})
         2'b10:   mode = MODE_LOAD;
         2'b11:   mode = MODE_KEEP;
         2'b00:   mode = MODE_DEMUX;
         default: mode = MODE_WIPE;
      endcase
   end

endmodule

// File: rtl/addr_latch_decode.sv
module addr_latch_decode #(
   parameter int unsigned ADDR_W      = 3,
   parameter bit          SHIFT_STYLE = 1'b1,
   localparam int unsigned NUM_BITS   = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0]   sel,
   output logic [NUM_BITS-1:0] hit
);

   generate
      if (SHIFT_STYLE) begin : g_shift
         assign hit = NUM_BITS'(1) << sel;
      end else begin : g_compare
         for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
            assign hit[i] = (sel == ADDR_W'(i));
         end
      end
   endgenerate

endmodule

// File: rtl/addr_latch_cell.sv
module addr_latch_cell
   import addr_latch_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  op_mode_t mode,
   input  logic     hit,
   input  logic     din,
   output logic     q
);

   logic q_next;

   always_comb begin
      q_next = q;
      unique case (mode)
         MODE_LOAD:  if (hit) q_next = din;
         MODE_KEEP:  q_next = q;
         MODE_DEMUX: q_next = hit & din;
         MODE_WIPE:  q_next = 1'b0;
         default:    q_next = q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= q_next;
   end

endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
   import addr_latch_pkg::*;
#(
   parameter int unsigned ADDR_W      = 3,
   parameter bit          SHIFT_STYLE = 1'b1,
   localparam int unsigned NUM_BITS   = 1 << ADDR_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                din,
   input  logic [ADDR_W-1:0]   sel,
   input  logic                wr_en_n,
   input  logic                clr_n,
   output logic [NUM_BITS-1:0] q
);

   generate
      if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_width
         $error("addr_latch_bank: ADDR_W out of supported range");
      end
   endgenerate

   op_mode_t            mode;
   logic [NUM_BITS-1:0] hit;

   addr_latch_mode mode_i (
      .clr_n   (clr_n),
      .wr_en_n (wr_en_n),
      .mode    (mode)
   );

   addr_latch_decode #(
      .ADDR_W      (ADDR_W),
      .SHIFT_STYLE (SHIFT_STYLE)
   ) dec_i (
      .sel (sel),
      .hit (hit)
   );

   generate
      for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
         addr_latch_cell cell_i (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .hit  (hit[i]),
            .din  (din),
            .q    (q[i])
         );
      end
   endgenerate

endmodule

// File: rtl/addr_latch_bank_chk.sv
module addr_latch_bank_chk #(
   parameter int unsigned ADDR_W      = 3,
   localparam int unsigned NUM_BITS   = 1 << ADDR_W
) (
   input logic                clk,
   input logic                rst,
   input logic                din,
   input logic [ADDR_W-1:0]   sel,
   input logic                wr_en_n,
   input logic                clr_n,
   input logic [NUM_BITS-1:0] q
);

   logic [NUM_BITS-1:0] sel_vec;
   logic                rst_q;

   always_comb begin
      sel_vec      = '0;
      sel_vec[sel] = 1'b1;
   end

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst_q) begin
         a_r1_reset_zero: assert (q == '0)
            else $error("R1/R9: bank not zero after reset");
      end
   end

   a_r2_load_one_bit: assert property (@(posedge clk) disable iff (rst)
      (clr_n && !wr_en_n) |=>
         (q[$past(sel)] == $past(din)) &&
         ((q & ~$past(sel_vec)) == ($past(q) & ~$past(sel_vec))));

   a_r4_keep_stable: assert property (@(posedge clk) disable iff (rst)
      (clr_n && wr_en_n) |=> $stable(q));

   a_r5_wipe_all: assert property (@(posedge clk) disable iff (rst)
      (!clr_n && wr_en_n) |=> (q == '0));

   a_r6_demux_pattern: assert property (@(posedge clk) disable iff (rst)
      (!clr_n && !wr_en_n) |=>
         (q == ($past(din) ? $past(sel_vec) : '0)));

   a_r6_demux_onehot: assert property (@(posedge clk) disable iff (rst)
      (!clr_n && !wr_en_n) |=> $onehot0(q));

   a_r8_sel_steady: assert property (@(posedge clk) disable iff (rst)
      (!wr_en_n && $past(!wr_en_n)) |-> $stable(sel));

endmodule

bind addr_latch_bank addr_latch_bank_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/addr_latch_bank_tb_top.sv
module addr_latch_bank_tb_top;

   localparam int AW = 3;
   localparam int NB = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          din = 1'b0;
   logic [AW-1:0] sel = '0;
   logic          wr_en_n = 1'b1;
   logic          clr_n = 1'b1;
   logic [NB-1:0] q;

   logic [NB-1:0] exp_q = '0;
   int            n_chk = 0;
   int            n_err = 0;
   int            cyc_cnt = 0;

   always #5 clk = ~clk;

   addr_latch_bank #(.ADDR_W(AW)) dut_i (
      .clk     (clk),
      .rst     (rst),
      .din     (din),
      .sel     (sel),
      .wr_en_n (wr_en_n),
      .clr_n   (clr_n),
      .q       (q)
   );

   always @(posedge clk) begin
      cyc_cnt <= cyc_cnt + 1;
      if (cyc_cnt > 150000) begin
         n_err = n_err + 1;
         $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc_cnt);
         $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: q actual %b expected %b", req, act, exp);
      end
   endtask

   // One clock: drive at negedge, model at posedge, compare at next negedge.
   task automatic step(input logic r, input logic c, input logic e,
                       input logic d, input logic [AW-1:0] s);
      logic [NB-1:0] one;
      string         tag;
      rst = r; clr_n = c; wr_en_n = e; din = d; sel = s;
      @(posedge clk);
      one = NB'(1) << s;
      if (r) begin
         exp_q = '0; tag = "R9";
      end else begin
         case ({c, e})
            2'b10: begin exp_q = d ? (exp_q | one) : (exp_q & ~one); tag = "R2"; end
            2'b11: tag = "R4";
            2'b00: begin exp_q = d ? one : '0; tag = "R6"; end
            default: begin exp_q = '0; tag = "R5"; end
         endcase
      end
      @(negedge clk);
      chk(tag, q, exp_q);
   endtask

   task automatic fill_ones();
      for (int k = 0; k < NB; k++) begin
         step(0, 1, 1, 0, AW'(k));
         step(0, 1, 0, 1, AW'(k));
      end
   endtask

   initial begin
      logic e_prev;
      logic [AW-1:0] s_cur;
      @(negedge clk);
      step(1, 1, 1, 0, '0);
      chk("R1", q, '0);

      // R3: each select value reaches exactly the matching bit
      for (int k = 0; k < NB; k++) begin
         step(0, 1, 1, 0, AW'(k));
         step(0, 0, 0, 1, AW'(k));
         chk("R3", q, NB'(1) << k);
      end

      // R2 and R4: load sweep with keep cycles that toggle din and sel
      step(0, 0, 1, 0, '0);
      for (int k = 0; k < NB; k++) begin
         for (int d = 0; d < 2; d++) begin
            step(0, 1, 1, ~d[0], AW'(NB - 1 - k));
            step(0, 1, 1, d[0], AW'(k));
            step(0, 1, 0, d[0], AW'(k));
         end
         step(0, 1, 0, 1, AW'(k));
      end
      chk("R2", q, '1);

      // R6: demux after preloading ones, both data values, every select
      for (int k = 0; k < NB; k++) begin
         for (int d = 0; d < 2; d++) begin
            fill_ones();
            step(0, 1, 1, 0, AW'(k));
            step(0, 0, 0, d[0], AW'(k));
            chk("R6", q, d[0] ? (NB'(1) << k) : '0);
         end
      end

      // R5: wipe from all ones
      fill_ones();
      step(0, 0, 1, 1, 3'd5);
      chk("R5", q, '0);

      // R7: bit follows din while enabled, keeps last value after release
      step(0, 1, 1, 0, 3'd2);
      step(0, 1, 0, 1, 3'd2);
      step(0, 1, 0, 0, 3'd2);
      step(0, 1, 0, 1, 3'd2);
      step(0, 1, 1, 0, 3'd2);
      step(0, 1, 1, 0, 3'd2);
      chk("R7", q, 8'b0000_0100);

      // R8: a later load to another address leaves an earlier bit alone
      step(0, 1, 1, 0, 3'd6);
      step(0, 1, 0, 1, 3'd6);
      step(0, 1, 1, 1, 3'd1);
      step(0, 1, 0, 0, 3'd1);
      chk("R8", q, 8'b0100_0100);

      // R9: reset wins over a load in the same cycle
      fill_ones();
      step(1, 1, 0, 1, 3'd0);
      chk("R9", q, '0);

      // Random mix; sel moves only when enable was or is high
      e_prev = 1'b1;
      s_cur  = '0;
      for (int i = 0; i < 4000; i++) begin
         logic r, c, e, d;
         logic [31:0] rnd;
         rnd = $urandom;
         r = (rnd[5:0] == 6'd0);
         c = rnd[6] | rnd[7];
         e = r ? 1'b1 : rnd[8];
         d = rnd[9];
         if (e_prev || e) s_cur = rnd[12:10];
         step(r, c, e, d, s_cur);
         e_prev = e;
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule